// File: doc/BRIEF.md
# Asynchronous Static Memory Controller

This block sits between a synchronous host and an asynchronous 128K x 8 static memory. It takes one read or write request at a time from a valid/ready host port. For each request it produces the active-low chip-enable, output-enable and write-enable strobes, a 17-bit address and an 8-bit bidirectional data bus. Every minimum time of the memory is met by counting clock cycles. The cycle counts come from a speed-grade parameter and a clock-period parameter, and each nanosecond figure is rounded up to whole cycles when the design is elaborated.

A read holds chip enable and output enable low until the access time has passed. It samples the bus on that edge and returns the byte with a one-cycle valid pulse. A write is ended by write enable. Chip enable and the driven data stay in place for a settling window after write enable rises, which covers both the short-recovery and the long-hold timing alternatives. The controller never drives the data bus while output enable is low. After a read it also waits for the memory's output turn-off time before it accepts the next request.

Top module: `asram_ctrl`

## Requirements
- R1: The memory address is 17 bits and the data 8 bits. A byte written to an address is returned by a later read of that address, and the address pins stay constant for as long as chip enable is low.
- R2: A read request lowers chip enable and output enable together on the acceptance edge, with write enable high. The bus is sampled on the edge nAcc cycles later, where nAcc = ceil(max(read cycle, address access, enable access, output-enable access) / clock period). Both strobes rise on that same edge.
- R3: The read byte is presented on rspData with rspValid high for exactly one cycle. It starts on the cycle after the sample edge, and rspData holds the byte after the pulse.
- R4: A write request lowers chip enable and write enable together on the acceptance edge and starts driving the write byte. Write enable stays low for nWp = ceil(max(write pulse, enable-to-end, address-to-end, data setup) / clock period) cycles. Output enable stays high throughout.
- R5: After write enable rises, chip enable stays low and the write byte stays driven for nHold = max(ceil(15 ns/T), ceil(data hold/T), ceil(write cycle/T) - nWp, 1) cycles. Chip enable then rises and the bus is released.
- R6: Output enable is high whenever the controller drives the data bus. Write enable and output enable are never low together.
- R7: After output enable rises at the end of a read, no new chip-enable cycle starts within nOhz = ceil(output turn-off time / T) cycles. The controller never drives the bus while the memory may still be driving it.
- R8: reqReady is high only while the controller is idle and reqValid is high. It is high for exactly one cycle per request, and the request is taken on that edge.
- R9: The parameter SPEED_NS picks the grade, 70, 85, 120 or 150 ns. Per grade, the read cycle and access time are 70/85/120/150 ns, output-enable access is 35/45/60/70 ns and output turn-off is 25/25/35/50 ns. The write cycle is 70/85/120/150 ns, enable-to-end 65/75/100/100 ns, address-to-end 65/75/100/90 ns, write pulse 55/65/85/90 ns, data setup 30/35/45/50 ns and data hold 10/10/10/0 ns.
- R10: During reset all three strobes are high, the bus is released and rspValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Request taken this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Request address |
| reqWdata | input | 8 | Write byte |
| rspValid | output | 1 | One-cycle read-data strobe |
| rspData | output | 8 | Last byte read |
| sramAddr | output | 17 | Memory address pins |
| sramCeN | output | 1 | Chip enable, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write enable, active low |
| sramDq | inout | 8 | Bidirectional memory data |

## Verification
The bench runs the 85 ns grade at a 10 ns clock against a timed memory model. The model returns a poison byte until the access time has elapsed, so a controller that samples one cycle early reads the wrong data, and a latency count off by one is also reported. Write-enable width and the chip-enable hold after write enable are timed to the exact cycle. A short pulse or a write ended by chip enable shows up there. Back-to-back read-then-write pairs test the turnaround: a controller that drives the bus too soon after a read collides with the model's still-active output. An address sweep with walking ones and both ends of the range catches lost or swapped address bits.

// File: rtl/asram_ctrl_pkg.sv
`timescale 1ns/1ps
package asram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_TURN, ST_WRITE, ST_WHOLD
  } ctlState_t;

  // strobe bundle from control to datapath (next-cycle pin values + actions)
  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic dqDrive;
    logic latchReq;
    logic sampleRd;
  } strobes_t;

  typedef enum int {
    TM_RC, TM_ACC, TM_OE, TM_OHZ, TM_WC, TM_CW, TM_AW, TM_WP, TM_DW, TM_DH, TM_WR
  } timeField_t;

  function automatic int gradeIndex(int speedNs);
    if (speedNs <= 70)       return 0;
    else if (speedNs <= 85)  return 1;
    else if (speedNs <= 120) return 2;
    return 3;
  endfunction

  function automatic int pick4(int idx, int g0, int g1, int g2, int g3);
    case (idx)
      0:       return g0;
      1:       return g1;
      2:       return g2;
      default: return g3;
    endcase
  endfunction

  // minimum times in ns per grade
  function automatic int gradeTime(int speedNs, timeField_t f);
    int gi;
    gi = gradeIndex(speedNs);
    case (f)
      TM_RC:   return pick4(gi, 70, 85, 120, 150);
      TM_ACC:  return pick4(gi, 70, 85, 120, 150);
      TM_OE:   return pick4(gi, 35, 45, 60, 70);
      TM_OHZ:  return pick4(gi, 25, 25, 35, 50);
      TM_WC:   return pick4(gi, 70, 85, 120, 150);
      TM_CW:   return pick4(gi, 65, 75, 100, 100);
      TM_AW:   return pick4(gi, 65, 75, 100, 90);
      TM_WP:   return pick4(gi, 55, 65, 85, 90);
      TM_DW:   return pick4(gi, 30, 35, 45, 50);
      TM_DH:   return pick4(gi, 10, 10, 10, 0);
      default: return 15; // recovery when the long-hold alternative is used
    endcase
  endfunction

  function automatic int maxInt(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int toCycles(int ns, int periodNs);
    if (ns <= 0) return 1;
    return maxInt(1, (ns + periodNs - 1) / periodNs);
  endfunction

  function automatic int readCycles(int speedNs, int periodNs);
    int ns;
    ns = maxInt(maxInt(gradeTime(speedNs, TM_RC), gradeTime(speedNs, TM_ACC)),
                gradeTime(speedNs, TM_OE));
    return toCycles(ns, periodNs);
  endfunction

  function automatic int writePulseCycles(int speedNs, int periodNs);
    int ns;
    ns = maxInt(maxInt(gradeTime(speedNs, TM_WP), gradeTime(speedNs, TM_CW)),
                maxInt(gradeTime(speedNs, TM_AW), gradeTime(speedNs, TM_DW)));
    return toCycles(ns, periodNs);
  endfunction

  function automatic int writeHoldCycles(int speedNs, int periodNs);
    int h;
    h = maxInt(toCycles(gradeTime(speedNs, TM_WR), periodNs),
               toCycles(gradeTime(speedNs, TM_DH), periodNs));
    h = maxInt(h, toCycles(gradeTime(speedNs, TM_WC), periodNs)
                  - writePulseCycles(speedNs, periodNs));
    return maxInt(h, 1);
  endfunction

  function automatic int turnCycles(int speedNs, int periodNs);
    return toCycles(gradeTime(speedNs, TM_OHZ), periodNs);
  endfunction

endpackage

// File: rtl/asram_ctrl_ctl.sv
`timescale 1ns/1ps
module asram_ctrl_ctl
  import asram_ctrl_pkg::*;
#(
  parameter int SPEED_NS      = 70,
  parameter int CLK_PERIOD_NS = 10
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  output logic     reqReady,
  output strobes_t strbNext
);

  localparam int RD_CYC   = readCycles(SPEED_NS, CLK_PERIOD_NS);
  localparam int WP_CYC   = writePulseCycles(SPEED_NS, CLK_PERIOD_NS);
  localparam int HOLD_CYC = writeHoldCycles(SPEED_NS, CLK_PERIOD_NS);
  localparam int TURN_CYC = turnCycles(SPEED_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC  = maxInt(maxInt(RD_CYC, WP_CYC), maxInt(HOLD_CYC, TURN_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  ctlState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             cntDone;

  assign cntDone = (cnt == '0);

  always_comb begin
    stateNext         = state;
    cntNext           = cnt;
    reqReady          = 1'b0;
    strbNext.latchReq = 1'b0;
    strbNext.sampleRd = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          reqReady          = 1'b1;
          strbNext.latchReq = 1'b1;
          if (reqWrite) begin
            stateNext = ST_WRITE;
            cntNext   = CNT_W'(WP_CYC - 1);
          end else begin
            stateNext = ST_READ;
            cntNext   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (cntDone) begin
          strbNext.sampleRd = 1'b1;
          stateNext         = ST_TURN;
          cntNext           = CNT_W'(TURN_CYC - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_TURN: begin
        if (cntDone) stateNext = ST_IDLE;
        else         cntNext   = cnt - 1'b1;
      end
      ST_WRITE: begin
        if (cntDone) begin
          stateNext = ST_WHOLD;
          cntNext   = CNT_W'(HOLD_CYC - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_WHOLD: begin
        if (cntDone) stateNext = ST_IDLE;
        else         cntNext   = cnt - 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
    // pin levels follow the state being entered
    strbNext.ceN     = !(stateNext == ST_READ || stateNext == ST_WRITE || stateNext == ST_WHOLD);
    strbNext.oeN     = !(stateNext == ST_READ);
    strbNext.weN     = !(stateNext == ST_WRITE);
    strbNext.dqDrive = (stateNext == ST_WRITE || stateNext == ST_WHOLD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady);

  // R2
  sample_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    strbNext.sampleRd |=> (state == ST_TURN));

endmodule

// File: rtl/asram_ctrl_dp.sv
`timescale 1ns/1ps
module asram_ctrl_dp
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strbNext,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  inout  wire  [DATA_W-1:0] sramDq
);

  logic              dqDriveQ;
  logic [DATA_W-1:0] wrDataQ;

  // pin registers: strobes change only on clock edges, never glitch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sramCeN  <= 1'b1;
      sramOeN  <= 1'b1;
      sramWeN  <= 1'b1;
      dqDriveQ <= 1'b0;
    end else begin
      sramCeN  <= strbNext.ceN;
      sramOeN  <= strbNext.oeN;
      sramWeN  <= strbNext.weN;
      dqDriveQ <= strbNext.dqDrive;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sramAddr <= '0;
      wrDataQ  <= '0;
    end else if (strbNext.latchReq) begin
      sramAddr <= reqAddr;
      wrDataQ  <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strbNext.sampleRd;
      if (strbNext.sampleRd) rspData <= sramDq;
    end
  end

  assign sramDq = dqDriveQ ? wrDataQ : {DATA_W{1'bz}};

  // R6
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> sramOeN);

  // R6
  drive_oe_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqDriveQ |-> sramOeN);

  // R2
  oe_within_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sramOeN |-> !sramCeN);

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R5
  we_ends_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> (!sramCeN && dqDriveQ));

  // R1
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr));

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_ctrl_pkg::*;
#(
  parameter int SPEED_NS      = 70,
  parameter int CLK_PERIOD_NS = 10,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  inout  wire  [DATA_W-1:0] sramDq
);

  strobes_t strbNext;

  asram_ctrl_ctl #(
    .SPEED_NS     (SPEED_NS),
    .CLK_PERIOD_NS(CLK_PERIOD_NS)
  ) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strbNext(strbNext)
  );

  asram_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strbNext(strbNext),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .rspValid(rspValid),
    .rspData (rspData),
    .sramAddr(sramAddr),
    .sramCeN (sramCeN),
    .sramOeN (sramOeN),
    .sramWeN (sramWeN),
    .sramDq  (sramDq)
  );

  // R8
  ready_starts_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !sramCeN);

endmodule

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;

  localparam int CLK_NS = 10;
  localparam int GRADE  = 85;
  // R9: 85 ns grade figures, converted independently of the design
  localparam int T_ACC  = 85;
  localparam int T_OHZ  = 25;
  localparam int N_ACC  = 9;  // ceil(max(85,85,45)/10)
  localparam int N_WP   = 8;  // ceil(max(65,75,75,35)/10)
  localparam int N_HOLD = 2;  // max(ceil(15/10), ceil(10/10), 9-8, 1)
  localparam int N_OHZ  = 3;  // ceil(25/10)

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rspValid;
  logic [7:0]  rspData;
  logic [16:0] sramAddr;
  logic        sramCeN, sramOeN, sramWeN;
  wire  [7:0]  sramDq;

  logic        modelDrive = 1'b0;
  logic [7:0]  modelVal = '0;
  assign sramDq = modelDrive ? modelVal : 8'bz;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_NS/2) clk = ~clk;

  asram_ctrl #(.SPEED_NS(GRADE), .CLK_PERIOD_NS(CLK_NS)) u_asram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .sramAddr(sramAddr),
    .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN), .sramDq(sramDq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- timed memory model ----------------
  logic [7:0] mem [int];
  logic [7:0] curWdata = '0;
  bit  started = 0, inWrite = 0, oeRiseSeen = 0, gapArmed = 0;
  bit  wrDqBad = 0;
  int  exclBad = 0, contBad = 0;
  real tCeFall = 0.0, tWeFall = 0.0, tWeRise = 0.0, tOeRise = 0.0;

  function automatic logic [7:0] memRead(input logic [16:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  initial begin
    #0.5;
    forever begin
      if (started) begin
        if (!sramCeN && !sramOeN) begin
          modelDrive = 1'b1;
          modelVal   = ($realtime + 0.5 >= tCeFall + T_ACC) ? memRead(sramAddr) : 8'hEE;
        end else if (oeRiseSeen && ($realtime - tOeRise < T_OHZ)) begin
          modelDrive = 1'b1;
        end else begin
          modelDrive = 1'b0;
        end
        if (!sramWeN && !sramOeN) exclBad++;
        if (modelDrive && !sramCeN && sramOeN) contBad++;
        if (inWrite && !sramCeN && sramOeN && !modelDrive && sramDq !== curWdata) wrDqBad = 1;
      end
      #1;
    end
  end

  always @(negedge sramCeN) if (started) begin
    tCeFall = $realtime;
    if (gapArmed) begin
      chk(($realtime - tOeRise) >= N_OHZ * CLK_NS, "R7", "turnaround ns",
          int'($realtime - tOeRise), N_OHZ * CLK_NS);
      gapArmed = 0;
    end
  end

  always @(posedge sramOeN) if (started) begin
    tOeRise = $realtime; oeRiseSeen = 1; gapArmed = 1;
  end

  always @(negedge sramWeN) if (started) begin
    tWeFall = $realtime; inWrite = 1; wrDqBad = 0;
  end

  always @(posedge sramWeN) if (started && inWrite) begin
    chk(($realtime - tWeFall) == N_WP * CLK_NS, "R4 R9", "write pulse ns",
        int'($realtime - tWeFall), N_WP * CLK_NS);
    if (!sramCeN) mem[int'(sramAddr)] = sramDq;
    tWeRise = $realtime;
  end

  always @(posedge sramCeN) if (started && inWrite) begin
    chk(($realtime - tWeRise) == N_HOLD * CLK_NS, "R5 R9", "hold after WE ns",
        int'($realtime - tWeRise), N_HOLD * CLK_NS);
    chk(!wrDqBad, "R5", "data driven through write", int'(wrDqBad), 0);
    inWrite = 0;
  end

  // ---------------- host tasks (called at a negedge) ----------------
  task automatic issue(input logic w, input logic [16:0] a, input logic [7:0] d);
    bit r;
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    r = 0;
    while (!r) begin
      #1; r = reqReady;
      @(negedge clk);
    end
    chk(reqReady == 1'b0, "R8", "ready after accept", int'(reqReady), 0);
    reqValid = 1'b0;
  endtask

  logic [7:0] shadow [int];

  task automatic doWrite(input logic [16:0] a, input logic [7:0] d);
    curWdata = d;
    issue(1'b1, a, d);
    chk(!sramCeN && !sramWeN && sramOeN, "R4", "write strobes {ce,we,oe}",
        int'({sramCeN, sramWeN, sramOeN}), 1);
    shadow[int'(a)] = d;
    while (!sramCeN) @(negedge clk);
  endtask

  task automatic doRead(input logic [16:0] a);
    int k;
    logic [7:0] exp, held;
    exp = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    issue(1'b0, a, 8'h00);
    chk(!sramCeN && !sramOeN && sramWeN, "R2", "read strobes {ce,oe,we}",
        int'({sramCeN, sramOeN, sramWeN}), 1);
    k = 1;
    while (!rspValid && k < 64) begin @(negedge clk); k++; end
    chk(k == N_ACC + 1, "R2 R9", "read latency cycles", k, N_ACC + 1);
    chk(rspData == exp, "R1", $sformatf("read data @%05h", a), int'(rspData), int'(exp));
    held = rspData;
    @(negedge clk);
    chk(!rspValid, "R3", "valid pulse width", int'(rspValid), 0);
    chk(rspData == held, "R3", "data held", int'(rspData), int'(held));
  endtask

  function automatic logic [7:0] pat(input logic [16:0] a);
    return 8'(a[7:0] * 8'd29 + 8'd7) ^ a[16:9];
  endfunction

  initial begin
    #(CLK_NS * 150000);
    testsFailed++; testsRun++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [16:0] addrs [36];
    logic [16:0] lf;
    repeat (4) @(negedge clk);
    // R10
    chk(sramCeN && sramOeN && sramWeN, "R10", "strobes in reset",
        int'({sramCeN, sramOeN, sramWeN}), 7);
    chk(!rspValid, "R10", "rspValid in reset", int'(rspValid), 0);
    chk(!reqReady, "R10", "ready in reset", int'(reqReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    started = 1;

    addrs[0] = 17'h00000;
    addrs[1] = 17'h1FFFF;
    for (int i = 0; i < 17; i++) addrs[2 + i] = 17'(1) << i;
    lf = 17'h0ACE1;
    for (int i = 19; i < 36; i++) begin
      lf = {lf[15:0], lf[16] ^ lf[13]};
      addrs[i] = lf;
    end

    for (int i = 0; i < 36; i++) doWrite(addrs[i], pat(addrs[i]));
    for (int i = 0; i < 36; i++) doRead(addrs[i]);

    // read immediately followed by write: turnaround (R7)
    for (int i = 0; i < 8; i++) begin
      doRead(addrs[i]);
      doWrite(addrs[i], ~pat(addrs[i]));
      doRead(addrs[i]);
    end

    repeat (5) @(negedge clk);
    chk(exclBad == 0, "R6", "WE and OE low together ticks", exclBad, 0);
    chk(contBad == 0, "R7", "bus contention ticks", contBad, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule